// File: doc/BRIEF.md
# OTP Packet Directory Scanner

This block sits in front of the read controller of a one-time-programmable array. That array stores a chain of packets of variable length. Each packet opens with a header word. Bits 15:8 of the header give the payload size. The next packet begins that many words plus two after the current one. After reset the block walks the chain from word 0. It asks the controller to load each packet and waits for the controller's busy indication to drop. It then records where the packet starts in a small directory indexed by a dense packet number, and keeps a running packet count and byte total.

When the walk ends, the block raises its done flag and accepts read requests on a valid/ready port. A request carries a packet number and a length in bytes. The block looks up the start word, loads the packet and streams the header word followed by the payload words on a valid/ready output. The stream stops when the requested length is covered or when the payload runs out. A number that is not in the directory is rejected with a one-cycle error pulse. A load that stays busy for too long ends with a timeout flag.

Top module: `otp_dir_scanner`

## Requirements
- R1: During reset and before the first clock edge after reset, `scan_done_o`, `req_ready_o`, `out_valid_o`, `ld_req_o`, `ovf_o` and `tmo_o` are all low.
- R2: The walk loads word 0 first. Each following load is at the previous load address plus the header's size field (bits 15:8) plus 2. Packet numbers are given from 0 upward in the order the packets are found.
- R3: `total_bytes_o` grows by 4 × (size field + 1) for each packet entered in the directory.
- R4: A header whose size field is zero ends the walk. That packet is not counted.
- R5: Before each load the byte total is compared with `BYTE_LIMIT` (default 11264). When the total is at or above it, the walk ends without issuing that load.
- R6: The directory holds `DEPTH` entries (default 64). If a further packet is found while the directory is full, the walk ends, `ovf_o` rises and `pkt_count_o` stays at `DEPTH`.
- R7: Every load is a one-cycle `ld_req_o` pulse with `ld_addr_o`. The holding registers are used only after `ld_busy_i` is seen low. If busy stays high for `TMO_CYC` polled cycles, the operation ends and `tmo_o` is set. `tmo_o` stays set until the next accepted request.
- R8: `req_ready_o` is low until the walk is done, and stays low while a read is being loaded or streamed.
- R9: A request whose packet number is greater than or equal to `pkt_count_o` produces a one-cycle `id_err_o` pulse, starts no load and sends no stream words.
- R10: A valid request streams N words, with N = min(1 + size, max(1, ceil(len/4))). The first word is the header. Word k ≥ 1 is payload index k−1, read through `pay_idx_o`, counting up from 0. `out_last_o` marks word N.
- R11: While `out_valid_o` is high and `out_ready_i` is low, the output word and the last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_req_o | output | 1 | Load command pulse to the read controller |
| ld_addr_o | output | AW | Word address for the load |
| ld_busy_i | input | 1 | Controller busy, high while a load is in progress |
| hdr_word_i | input | 32 | Header holding register |
| pay_idx_o | output | 8 | Payload word index |
| pay_word_i | input | 32 | Payload word at `pay_idx_o` |
| scan_done_o | output | 1 | Walk finished |
| pkt_count_o | output | CNTW | Packets in the directory |
| total_bytes_o | output | BW | Accumulated byte size |
| ovf_o | output | 1 | Directory overflow |
| tmo_o | output | 1 | Busy timeout |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request accepted |
| req_id_i | input | IDW | Requested packet number |
| req_len_i | input | LENW | Requested length in bytes |
| id_err_o | output | 1 | Unknown packet number pulse |
| out_valid_o | output | 1 | Stream word valid |
| out_ready_i | input | 1 | Stream sink ready |
| out_data_o | output | 32 | Stream word |
| out_last_o | output | 1 | Final word of the stream |

## Verification
The checks assume that the controller raises `ld_busy_i` no earlier than the edge that samples `ld_req_o`, and that `pay_word_i` follows `pay_idx_o` within the same cycle. The output-hold check also assumes that the controller leaves its holding registers alone between loads. The bench controller model meets these assumptions: it starts busy on the edge of the request, keeps a poison value in its registers while busy, and decodes payload reads combinationally from its memory. Stream backpressure follows a fixed ready pattern. Requests are raised only while `req_ready_o` is high, so the design is never offered a request it would have to drop.

// File: rtl/otp_scan_pkg.sv
package otp_scan_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SIZE_W = 8;

  // size field sits in header bits 15:8
  function automatic logic [SIZE_W-1:0] hdr_size(input logic [WORD_W-1:0] w);
    return w[15:8];
  endfunction

  typedef enum logic [2:0] {
    ST_SCAN_CHK,
    ST_SCAN_WAIT,
    ST_IDLE,
    ST_RD_LOAD,
    ST_RD_WAIT,
    ST_RD_HDR,
    ST_RD_PAY
  } scan_state_e;
endpackage

// File: rtl/otp_busy_wait.sv
module otp_busy_wait #(
  parameter int unsigned AW      = 16,
  parameter int unsigned TMO_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          ld_req_o,
  output logic [AW-1:0] ld_addr_o,
  input  logic          ld_busy_i,
  output logic          done_o,
  output logic          tmo_o
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {W_IDLE, W_REQ, W_POLL} wait_e;

  wait_e         st_q;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          limit;

  assign limit = (cnt_q == CW'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      req_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (start_i) begin
          st_q   <= W_REQ;
          req_q  <= 1'b1;
          addr_q <= addr_i;
        end
        W_REQ: begin
          req_q <= 1'b0;
          cnt_q <= '0;
          st_q  <= W_POLL;
        end
        default: begin
          if (!ld_busy_i || limit) st_q <= W_IDLE;
          else                     cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign ld_req_o  = req_q;
  assign ld_addr_o = addr_q;
  assign done_o    = (st_q == W_POLL) && !ld_busy_i;
  assign tmo_o     = (st_q == W_POLL) && ld_busy_i && limit;
endmodule

// File: rtl/otp_dir_table.sv
module otp_dir_table #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 16,
  localparam int unsigned IXW  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [IXW-1:0] wr_idx_i,
  input  logic [AW-1:0]  wr_off_i,
  input  logic [IXW-1:0] rd_idx_i,
  output logic [AW-1:0]  rd_off_o
);
  logic [DEPTH*AW-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] off_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                off_q <= '0;
      else if (wr_en_i && wr_idx_i == IXW'(g))    off_q <= wr_off_i;
    end
    assign flat[g*AW +: AW] = off_q;
  end

  assign rd_off_o = flat[rd_idx_i*AW +: AW];
endmodule

// File: rtl/otp_dir_scanner.sv
module otp_dir_scanner
  import otp_scan_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned BYTE_LIMIT = 11264,
  parameter int unsigned TMO_CYC    = 64,
  parameter int unsigned IDW        = 8,
  parameter int unsigned LENW       = 16,
  localparam int unsigned CNTW      = $clog2(DEPTH + 1),
  localparam int unsigned IXW       = $clog2(DEPTH),
  localparam int unsigned BW        = $clog2(BYTE_LIMIT + 4 * (1 << SIZE_W) + 1),
  localparam int unsigned WLW       = LENW - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            ld_req_o,
  output logic [AW-1:0]   ld_addr_o,
  input  logic            ld_busy_i,
  input  logic [31:0]     hdr_word_i,
  output logic [7:0]      pay_idx_o,
  input  logic [31:0]     pay_word_i,
  output logic            scan_done_o,
  output logic [CNTW-1:0] pkt_count_o,
  output logic [BW-1:0]   total_bytes_o,
  output logic            ovf_o,
  output logic            tmo_o,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [IDW-1:0]  req_id_i,
  input  logic [LENW-1:0] req_len_i,
  output logic            id_err_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [31:0]     out_data_o,
  output logic            out_last_o
);
  scan_state_e       st_q;
  logic [AW-1:0]     pos_q, off_q, tbl_off;
  logic [CNTW-1:0]   cnt_q;
  logic [BW-1:0]     bytes_q;
  logic              ovf_q, tmo_q, err_q;
  logic [31:0]       hdr_q;
  logic [WLW-1:0]    wleft_q, wneed;
  logic [SIZE_W-1:0] pleft_q, idx_q, sz;
  logic              w_start, w_done, w_tmo;
  logic [AW-1:0]     w_addr;
  logic              tbl_we, id_bad, at_limit;
  logic [LENW:0]     len_rnd;

  assign sz       = hdr_size(hdr_word_i);
  assign at_limit = (bytes_q >= BW'(BYTE_LIMIT));
  assign id_bad   = ({{CNTW{1'b0}}, req_id_i} >= {{IDW{1'b0}}, cnt_q});
  assign len_rnd  = {1'b0, req_len_i} + (LENW+1)'(3);
  assign wneed    = (req_len_i == '0) ? WLW'(1) : len_rnd[LENW:2];

  assign w_start = ((st_q == ST_SCAN_CHK) && !at_limit) || (st_q == ST_RD_LOAD);
  assign w_addr  = (st_q == ST_RD_LOAD) ? off_q : pos_q;
  assign tbl_we  = (st_q == ST_SCAN_WAIT) && w_done && (sz != '0) &&
                   (cnt_q != CNTW'(DEPTH));

  otp_busy_wait #(.AW(AW), .TMO_CYC(TMO_CYC)) u_wait (
    .clk_i, .rst_ni,
    .start_i  (w_start),
    .addr_i   (w_addr),
    .ld_req_o,
    .ld_addr_o,
    .ld_busy_i,
    .done_o   (w_done),
    .tmo_o    (w_tmo)
  );

  otp_dir_table #(.DEPTH(DEPTH), .AW(AW)) u_tbl (
    .clk_i, .rst_ni,
    .wr_en_i  (tbl_we),
    .wr_idx_i (cnt_q[IXW-1:0]),
    .wr_off_i (pos_q),
    .rd_idx_i (req_id_i[IXW-1:0]),
    .rd_off_o (tbl_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SCAN_CHK;
      pos_q   <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
      ovf_q   <= 1'b0;
      tmo_q   <= 1'b0;
      err_q   <= 1'b0;
      hdr_q   <= '0;
      wleft_q <= '0;
      pleft_q <= '0;
      idx_q   <= '0;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        ST_SCAN_CHK: st_q <= at_limit ? ST_IDLE : ST_SCAN_WAIT;
        ST_SCAN_WAIT: begin
          if (w_tmo) begin
            tmo_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (w_done) begin
            if (sz == '0) begin
              st_q <= ST_IDLE;
            end else if (cnt_q == CNTW'(DEPTH)) begin
              ovf_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              bytes_q <= bytes_q + BW'({sz, 2'b00}) + BW'(4);
              pos_q   <= pos_q + AW'(sz) + AW'(2);
              st_q    <= ST_SCAN_CHK;
            end
          end
        end
        ST_IDLE: if (req_valid_i) begin
          tmo_q <= 1'b0;
          if (id_bad) begin
            err_q <= 1'b1;
          end else begin
            off_q   <= tbl_off;
            wleft_q <= wneed;
            st_q    <= ST_RD_LOAD;
          end
        end
        ST_RD_LOAD: st_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (w_tmo) begin
            tmo_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (w_done) begin
            hdr_q   <= hdr_word_i;
            pleft_q <= sz;
            idx_q   <= '0;
            st_q    <= ST_RD_HDR;
          end
        end
        ST_RD_HDR: if (out_ready_i) begin
          wleft_q <= wleft_q - 1'b1;
          st_q    <= out_last_o ? ST_IDLE : ST_RD_PAY;
        end
        default: if (out_ready_i) begin
          wleft_q <= wleft_q - 1'b1;
          pleft_q <= pleft_q - 1'b1;
          idx_q   <= idx_q + 1'b1;
          if (out_last_o) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign scan_done_o   = (st_q != ST_SCAN_CHK) && (st_q != ST_SCAN_WAIT);
  assign pkt_count_o   = cnt_q;
  assign total_bytes_o = bytes_q;
  assign ovf_o         = ovf_q;
  assign tmo_o         = tmo_q;
  assign id_err_o      = err_q;
  assign req_ready_o   = (st_q == ST_IDLE);
  assign pay_idx_o     = idx_q;
  assign out_valid_o   = (st_q == ST_RD_HDR) || (st_q == ST_RD_PAY);
  assign out_data_o    = (st_q == ST_RD_HDR) ? hdr_q : pay_word_i;
  assign out_last_o    = (wleft_q == WLW'(1)) ||
                         ((st_q == ST_RD_PAY) && (pleft_q == SIZE_W'(1)));
endmodule

// File: rtl/otp_dir_scanner_chk.sv
module otp_dir_scanner_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNTW  = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ld_req_o,
  input logic            scan_done_o,
  input logic [CNTW-1:0] pkt_count_o,
  input logic            ovf_o,
  input logic            req_ready_o,
  input logic            id_err_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [31:0]     out_data_o,
  input logic            out_last_o
);
  // R7
  ld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_o |=> !ld_req_o);
  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));
  // R8
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_done_o |-> !req_ready_o);
  // R8
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !req_ready_o);
  // R6
  ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> pkt_count_o == CNTW'(DEPTH));
  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_err_o |-> !out_valid_o && !ld_req_o);
  // R2
  count_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> $stable(pkt_count_o));
endmodule

bind otp_dir_scanner otp_dir_scanner_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk_i, .rst_ni, .ld_req_o, .scan_done_o, .pkt_count_o, .ovf_o,
  .req_ready_o, .id_err_o, .out_valid_o, .out_ready_i, .out_data_o, .out_last_o
);

// File: tb/sim_otp_dir_scanner.sv
`timescale 1ns/1ps
module sim_otp_dir_scanner;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_req, ld_busy, scan_done, ovf, tmo, req_valid, req_ready, id_err;
  logic        out_valid, out_ready, out_last;
  logic [15:0] ld_addr, total_bytes, req_len;
  logic [31:0] hdr_word, pay_word, out_data;
  logic [7:0]  pay_idx, req_id;
  logic [6:0]  pkt_count;

  always #5 clk = ~clk;

  otp_dir_scanner u0 (
    .clk_i(clk), .rst_ni, .ld_req_o(ld_req), .ld_addr_o(ld_addr), .ld_busy_i(ld_busy),
    .hdr_word_i(hdr_word), .pay_idx_o(pay_idx), .pay_word_i(pay_word),
    .scan_done_o(scan_done), .pkt_count_o(pkt_count), .total_bytes_o(total_bytes),
    .ovf_o(ovf), .tmo_o(tmo), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_id_i(req_id), .req_len_i(req_len), .id_err_o(id_err),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last)
  );

  // controller model
  logic [31:0] mem [4096];
  int          lat = 3;
  int          bcnt;
  logic [15:0] addr_l;
  always_ff @(posedge clk) begin
    if (ld_req) begin
      addr_l <= ld_addr;
      if (lat == 0) begin
        ld_busy  <= 1'b0;
        hdr_word <= mem[ld_addr[11:0]];
      end else begin
        ld_busy  <= 1'b1;
        bcnt     <= lat;
        hdr_word <= 32'hDEAD_BEEF;
      end
    end else if (ld_busy) begin
      bcnt <= bcnt - 1;
      if (bcnt == 1) begin
        ld_busy  <= 1'b0;
        hdr_word <= mem[addr_l[11:0]];
      end
    end
  end
  logic [15:0] pay_a;
  assign pay_a    = addr_l + 16'd1 + {8'd0, pay_idx};
  assign pay_word = ld_busy ? 32'hBAD0_BAD0 : mem[pay_a[11:0]];

  int n_cmp = 0, n_bad = 0;
  int lds [0:127];
  int n_ld = 0;
  int offs [0:127];
  int sizes [0:127];
  int n_pk = 0;

  always @(negedge clk) if (rst_ni && ld_req) begin
    if (n_ld < 128) lds[n_ld] = int'(ld_addr);
    n_ld++;
  end

  task automatic chk(input string r, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_of(input int k, input int s);
    return {16'hC000 | 16'(k), 8'(s), 8'h5A};
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 4096; i++) mem[i] = {4'h1, 12'(i), 8'h00, 8'(i)};
    n_pk = 0;
  endtask

  task automatic add_pkt(input int s);
    int p;
    p = (n_pk == 0) ? 0 : offs[n_pk-1] + sizes[n_pk-1] + 2;
    offs[n_pk] = p; sizes[n_pk] = s;
    mem[p] = hdr_of(n_pk, s);
    n_pk++;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_valid = 1'b0; out_ready = 1'b0; req_id = '0; req_len = '0;
    repeat (3) @(negedge clk);
    n_ld = 0;
    rst_ni = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !scan_done; i++) @(negedge clk);
  endtask

  task automatic do_read(input int id, input int len, input string r);
    int  n, exp_n, cyc, cap;
    bit  got_last;
    logic [31:0] w [0:300];
    for (int i = 0; i < 2000 && !req_ready; i++) @(negedge clk);
    req_valid = 1'b1; req_id = 8'(id); req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (id >= int'(pkt_count)) begin
      chk({r, " R9 err pulse"}, id_err, 1);
      chk({r, " R9 no stream"}, out_valid, 0);
      return;
    end
    chk({r, " R9 no err"}, id_err, 0);
    n = 0; got_last = 0; cyc = 0;
    while (!got_last && cyc < 3000) begin
      out_ready = (cyc % 3) != 1;
      if (out_valid && n == 0) chk({r, " R8 busy"}, req_ready, 0);
      if (out_valid && out_ready) begin
        if (n <= 300) w[n] = out_data;
        n++;
        got_last = out_last;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    cap   = (len == 0) ? 1 : (len + 3) / 4;
    exp_n = (1 + sizes[id] < cap) ? 1 + sizes[id] : cap;
    chk({r, " R10 word count"}, n, exp_n);
    for (int k = 0; k < n && k < exp_n; k++)
      chk({r, " R10 word"}, w[k], (k == 0) ? hdr_of(id, sizes[id]) : mem[offs[id] + k]);
  endtask

  localparam logic [23:0] VEC [10] = '{
    {8'd0, 16'd0},  {8'd0, 16'd4},  {8'd0, 16'd5},  {8'd0, 16'd16},
    {8'd0, 16'd100}, {8'd1, 16'd12}, {8'd2, 16'd24}, {8'd3, 16'd9},
    {8'd4, 16'd4},  {8'd200, 16'd4}
  };

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int exp_ld [5] = '{0, 5, 8, 15, 19};
    // scenario A: sizes 3,1,5,2 then zero header
    fill_mem(); lat = 3;
    add_pkt(3); add_pkt(1); add_pkt(5); add_pkt(2);
    do_reset();
    #1;
    chk("R1 done", scan_done, 0);
    chk("R1 ready", req_ready, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 ld_req", ld_req, 0);
    chk("R1 flags", {ovf, tmo}, 0);
    @(negedge clk); @(negedge clk);
    chk("R8 ready before done", req_ready, 0);
    wait_done();
    chk("R2 count", pkt_count, 4);
    chk("R4 loads incl zero header", n_ld, 5);
    for (int i = 0; i < 5; i++) chk("R2 load addr", lds[i], exp_ld[i]);
    chk("R3 bytes", total_bytes, 60);
    chk("R6 no ovf", ovf, 0);
    for (int v = 0; v < 10; v++) do_read(int'(VEC[v][23:16]), int'(VEC[v][15:0]), "vec");

    // scenario B: 65 packets of size 1, zero busy latency
    fill_mem(); lat = 0;
    for (int i = 0; i < 65; i++) add_pkt(1);
    do_reset();
    wait_done();
    chk("R6 count", pkt_count, 64);
    chk("R6 ovf", ovf, 1);
    chk("R3 bytes B", total_bytes, 512);
    do_read(63, 8, "B last");
    do_read(64, 4, "B R9 beyond");

    // scenario C: byte limit
    fill_mem(); lat = 2;
    for (int i = 0; i < 12; i++) add_pkt(255);
    do_reset();
    wait_done();
    chk("R5 count", pkt_count, 11);
    chk("R5 bytes", total_bytes, 11264);
    chk("R5 loads", n_ld, 11);
    do_read(10, 2000, "C long");

    // scenario D: busy never clears in time
    fill_mem(); lat = 100;
    add_pkt(2);
    do_reset();
    wait_done();
    chk("R7 tmo set", tmo, 1);
    chk("R7 count", pkt_count, 0);
    do_read(0, 4, "D R9");
    chk("R7 tmo cleared", tmo, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule